// File: doc/BRIEF.md
# Multi-Channel Programmable Interval Timer

This block holds a bank of independent down-counting timer channels behind a small register interface. Each channel has a control word, a reload interval and a readable count. On each count-enable pulse an enabled channel counts down. When it runs out it raises a status bit. It then either reloads and keeps going (periodic) or stops and drops its own enable (one-shot). A shared enable mask gates one interrupt line per channel.

A channel's count rate comes from one of four tick inputs. Each tick is a single-cycle pulse in the block's clock domain, produced elsewhere. The selected tick then passes through a power-of-two divider whose exponent comes from the control word. Software programs the interval, writes the control word with the reload and enable bits, and services interrupts by writing ones to the status register.

Top module: `pit_bank`

## Requirements
- R1: Output `irq[c]` is high exactly when bit c of the status register (word address 1) and bit c of the interrupt enable register (word address 0) are both 1.
- R2: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: Channel c's registers are at word addresses 4+4c (control), 5+4c (interval) and 6+4c (count). The count register is read-only, and writes to it have no effect. The control bits are: bit 0 enable, bit 1 reload, bits [3:2] source select, bits [6:4] prescale exponent and bit 7 one-shot. The reload bit is a strobe and always reads back 0.
- R4: A channel advances only on ticks of the source its select field names. Ticks on the other sources leave its count unchanged.
- R5: A channel gets one count-enable every 2^e ticks of its selected source, where e is the prescale exponent. Every control write restarts the divider, so the first count-enable comes on the 2^e-th selected tick after that write.
- R6: A control write with the reload bit set loads the current interval into the count.
- R7: An enabled channel's count drops by exactly one per count-enable. A channel whose enable bit is 0 holds its count.
- R8: A count-enable while the count is 1 or 0 is an expiry. Expiry sets the channel's status bit, and a periodic channel reloads the interval into its count.
- R9: On expiry a one-shot channel sets its count to 0 and clears its own enable bit, and later ticks then leave it unchanged.
- R10: Writing the interval does not alter the running count; the new value is used at the next reload.
- R11: If an expiry and a status write clearing the same bit fall in the same cycle, the bit ends up set.
- R12: Reset sets the interrupt enable, status, interval and count registers to 0. It also sets every control register to 0x04: source 1, disabled, periodic, exponent 0.
- R13: A read strobe returns the addressed register on `bus_rdata` with `bus_rvalid` high one cycle later. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Single-cycle tick pulses of the four count sources |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The bench interleaves ticks on the selected source with ticks on a neighbouring source. A design that decoded the select field wrongly would then count on foreign ticks. Prescaled counting is checked against the exact tick on which the first decrement should land, which catches a divider that is off by one or not restarted. The bench also rewrites the interval mid-period and writes to the read-only count, either of which would corrupt the running count if handled wrongly. It lets a one-shot channel expire and then sends more ticks, so a channel that failed to drop its enable would keep counting. Finally, it lands a clearing status write in the very cycle of an expiry, where a design that let the clear win would lose the interrupt.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int SRC_N  = 4;
    localparam int SRCW   = 2;
    localparam int EXPW   = 3;
    localparam int DIVW   = (1 << EXPW) - 1;
    localparam int CTRLW  = 8;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 4;
    localparam int ADDR_IEN  = 0;
    localparam int ADDR_STAT = 1;

    typedef struct packed {
        logic            oneshot;
        logic [EXPW-1:0] pexp;
        logic [SRCW-1:0] src;
        logic            reload;
        logic            en;
    } pit_ctrl_t;

    localparam pit_ctrl_t CTRL_RST = '{oneshot: 1'b0, pexp: '0, src: 2'd1,
                                       reload: 1'b0, en: 1'b0};

    typedef enum logic [1:0] {
        OFS_CTRL = 2'd0,
        OFS_IVAL = 2'd1,
        OFS_CNT  = 2'd2
    } pit_ofs_e;

    function automatic int unsigned ch_addr(input int unsigned c, input pit_ofs_e o);
        return CH_BASE + CH_STRIDE * c + int'(o);
    endfunction

    function automatic logic [DIVW-1:0] div_mask(input logic [EXPW-1:0] e);
        return ~({DIVW{1'b1}} << e);
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_tick,
    input  logic [SRCW-1:0]  src_sel,
    input  logic [EXPW-1:0]  pexp,
    input  logic             restart,
    output logic             cnt_en
);
    logic [DIVW-1:0] div_q;
    logic            sel_tick;
    logic [DIVW-1:0] mask;

    assign sel_tick = src_tick[src_sel];
    assign mask     = div_mask(pexp);
    assign cnt_en   = sel_tick && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (sel_tick) begin
            div_q <= div_q + 1'b1;
        end
    end

    // R5: a divider that did not tick cannot leave its restart value behind
    a_r5_div_holds: assert property (@(posedge clk) disable iff (rst)
        (!sel_tick && !restart) |=> $stable(div_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CW = 32,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_tick,
    input  logic             ctrl_wr,
    input  logic             ival_wr,
    input  logic [DW-1:0]    wdata,
    output pit_ctrl_t        ctrl_q,
    output logic [CW-1:0]    ival_q,
    output logic [CW-1:0]    cnt_q,
    output logic             expire
);
    pit_ctrl_t     wr_ctrl;
    logic          cnt_en;
    logic          sel_tick;
    logic          at_end;

    assign wr_ctrl  = pit_ctrl_t'(wdata[CTRLW-1:0]);
    assign sel_tick = src_tick[ctrl_q.src];
    assign at_end   = (cnt_q <= CW'(1));
    assign expire   = !ctrl_wr && ctrl_q.en && cnt_en && at_end;

    pit_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .src_tick (src_tick),
        .src_sel  (ctrl_q.src),
        .pexp     (ctrl_q.pexp),
        .restart  (ctrl_wr),
        .cnt_en   (cnt_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            ival_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (ival_wr) begin
                ival_q <= wdata[CW-1:0];
            end
            if (ctrl_wr) begin
                ctrl_q        <= wr_ctrl;
                ctrl_q.reload <= 1'b0;
                if (wr_ctrl.reload) begin
                    cnt_q <= ival_q;
                end
            end else if (ctrl_q.en && cnt_en) begin
                if (at_end) begin
                    if (ctrl_q.oneshot) begin
                        cnt_q     <= '0;
                        ctrl_q.en <= 1'b0;
                    end else begin
                        cnt_q <= ival_q;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R4 / R7: without a selected tick or while disabled the count holds
    a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !sel_tick) |=> $stable(cnt_q));
    a_r7_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !ctrl_q.en) |=> $stable(cnt_q));
    a_r7_decrement: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && ctrl_q.en && cnt_en && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
    // R6: reload strobe copies interval
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_ctrl.reload) |=> (cnt_q == $past(ival_q)));
    // R8: periodic expiry reloads
    a_r8_periodic: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.oneshot) |=> (cnt_q == $past(ival_q) && ctrl_q.en));
    // R9: one-shot expiry stops
    a_r9_oneshot: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.oneshot) |=> (!ctrl_q.en && cnt_q == '0));
    // R3: reload bit never stored
    a_r3_reload_reads_zero: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !ctrl_q.reload);
endmodule

// File: rtl/pit_bank.sv
module pit_bank
    import pit_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int DW  = 32,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [3:0]     src_tick,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_rvalid,
    output logic [NCH-1:0] irq
);
    localparam int LAST_ADDR = CH_BASE + CH_STRIDE * NCH - 1;

    logic [NCH-1:0] ien_q;
    logic [NCH-1:0] stat_q;
    logic [NCH-1:0] expire_vec;
    logic [NCH-1:0] clr_vec;
    logic [DW-1:0]  rd_mux;
    pit_ctrl_t      ctrl_q [NCH];
    logic [CW-1:0]  ival_q [NCH];
    logic [CW-1:0]  cnt_q  [NCH];

    initial begin
        if (LAST_ADDR >= (1 << AW)) $error("address width too small for channel count");
        if (CW > DW) $error("count width exceeds data width");
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ctrl_wr, ival_wr;
        assign ctrl_wr = bus_wr && (bus_addr == AW'(ch_addr(c, OFS_CTRL)));
        assign ival_wr = bus_wr && (bus_addr == AW'(ch_addr(c, OFS_IVAL)));

        pit_channel #(.CW(CW), .DW(DW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .src_tick (src_tick[SRC_N-1:0]),
            .ctrl_wr  (ctrl_wr),
            .ival_wr  (ival_wr),
            .wdata    (bus_wdata),
            .ctrl_q   (ctrl_q[c]),
            .ival_q   (ival_q[c]),
            .cnt_q    (cnt_q[c]),
            .expire   (expire_vec[c])
        );
    end

    assign clr_vec = (bus_wr && bus_addr == AW'(ADDR_STAT)) ? bus_wdata[NCH-1:0] : '0;
    assign irq     = stat_q & ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            stat_q <= '0;
        end else begin
            if (bus_wr && bus_addr == AW'(ADDR_IEN)) begin
                ien_q <= bus_wdata[NCH-1:0];
            end
            stat_q <= (stat_q & ~clr_vec) | expire_vec;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == AW'(ADDR_IEN))  rd_mux = DW'(ien_q);
        if (bus_addr == AW'(ADDR_STAT)) rd_mux = DW'(stat_q);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(ch_addr(c, OFS_CTRL))) rd_mux = DW'(ctrl_q[c]);
            if (bus_addr == AW'(ch_addr(c, OFS_IVAL))) rd_mux = DW'(ival_q[c]);
            if (bus_addr == AW'(ch_addr(c, OFS_CNT)))  rd_mux = DW'(cnt_q[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    // R2: written-one bits without a coincident expiry are clear next cycle
    a_r2_w1c: assert property (@(posedge clk) disable iff (rst)
        (|clr_vec) |=> ((stat_q & $past(clr_vec & ~expire_vec)) == '0));
    // R11: an expiry always leaves its bit set
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|expire_vec) |=> ((stat_q & $past(expire_vec)) == $past(expire_vec)));
    // R13: read data follows one cycle after the strobe
    a_r13_rvalid: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);
    // R1: an interrupt line is never high without its status bit
    a_r1_irq_needs_stat: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~stat_q) == '0));
endmodule

// File: tb/pit_bank_bench.sv
module pit_bank_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  src_tick;
    logic        bus_wr, bus_rd;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [3:0]  irq;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pit_bank u_pit_bank (
        .clk(clk), .rst(rst), .src_tick(src_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq)
    );

    // monitor: pops expected items as read data arrives
    always @(negedge clk) begin
        if (bus_rvalid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
            end else begin
                item_t it;
                it = q.pop_front();
                if (bus_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = m;
            @(negedge clk);
            src_tick = 4'b0;
        end
    endtask

    task automatic chk_irq(input logic [3:0] e, input string tag);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, irq, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_tick = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        do_reset();
        // R12 reset state
        rd(5'd0, 32'h0,  "R12 ien reset");
        rd(5'd1, 32'h0,  "R12 status reset");
        rd(5'd4, 32'h04, "R12 ctrl reset");
        rd(5'd5, 32'h0,  "R12 interval reset");
        rd(5'd6, 32'h0,  "R12 count reset");
        chk_irq(4'b0, "R12 irq reset");
        rd(5'd3, 32'h0,  "R13 unmapped reads zero");

        // channel 0: periodic, source 0, exponent 0
        wr(5'd5, 32'd5);
        wr(5'd4, 32'h03);
        rd(5'd4, 32'h01, "R3 reload bit reads zero");
        rd(5'd6, 32'd5,  "R6 reload loads interval");
        tick(4'b0010, 3);
        rd(5'd6, 32'd5,  "R4 foreign source ignored");
        tick(4'b0001, 2);
        rd(5'd6, 32'd3,  "R7 decrement per tick");
        wr(5'd4, 32'h00);
        tick(4'b0001, 1);
        rd(5'd6, 32'd3,  "R7 disabled holds");
        wr(5'd4, 32'h01);
        tick(4'b0001, 2);
        rd(5'd6, 32'd1,  "R7 count at one");
        wr(5'd0, 32'h1);
        tick(4'b0001, 1);
        rd(5'd1, 32'h1,  "R8 expiry sets status");
        rd(5'd6, 32'd5,  "R8 periodic reload");
        chk_irq(4'b0001, "R1 irq with enable");
        wr(5'd0, 32'h0);
        chk_irq(4'b0000, "R1 irq masked");
        wr(5'd1, 32'h0);
        rd(5'd1, 32'h1,  "R2 zero write keeps bit");
        wr(5'd1, 32'h1);
        rd(5'd1, 32'h0,  "R2 one write clears bit");

        // R10: interval change mid-period
        wr(5'd5, 32'd2);
        rd(5'd6, 32'd5,  "R10 count untouched by interval write");
        tick(4'b0001, 4);
        rd(5'd6, 32'd1,  "R10 old period continues");
        tick(4'b0001, 1);
        rd(5'd6, 32'd2,  "R10 new interval used at reload");
        wr(5'd1, 32'h1);
        wr(5'd6, 32'd99);
        rd(5'd6, 32'd2,  "R3 count write ignored");

        // channel 1: one-shot, source 2, exponent 2
        wr(5'd9, 32'd2);
        wr(5'd8, 32'hAB);
        rd(5'd8, 32'hA9, "R3 ch1 control layout");
        tick(4'b0100, 3);
        rd(5'd10, 32'd2, "R5 no count before 2^e ticks");
        tick(4'b0100, 1);
        rd(5'd10, 32'd1, "R5 count on 4th tick");
        tick(4'b0100, 4);
        rd(5'd10, 32'd0, "R9 one-shot count zero");
        rd(5'd8, 32'hA8, "R9 one-shot clears enable");
        rd(5'd1, 32'h2,  "R8 ch1 status set");
        wr(5'd0, 32'h2);
        chk_irq(4'b0010, "R1 ch1 irq");
        wr(5'd1, 32'h2);
        tick(4'b0100, 8);
        rd(5'd10, 32'd0, "R9 stays stopped");
        rd(5'd1, 32'h0,  "R9 no further expiry");

        // R11: expiry and clear in same cycle
        tick(4'b0001, 1);
        rd(5'd6, 32'd1,  "R11 setup count one");
        @(negedge clk);
        src_tick = 4'b0001; bus_wr = 1'b1; bus_addr = 5'd1; bus_wdata = 32'h1;
        @(negedge clk);
        src_tick = 4'b0; bus_wr = 1'b0;
        rd(5'd1, 32'h1,  "R11 set wins over clear");
        rd(5'd6, 32'd2,  "R8 reload after coincident write");

        // reset during operation
        do_reset();
        rd(5'd1, 32'h0,  "R12 status after reset");
        rd(5'd4, 32'h04, "R12 ch0 ctrl after reset");
        rd(5'd10, 32'h0, "R12 ch1 count after reset");
        chk_irq(4'b0, "R12 irq after reset");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL pending reads: actual %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule